// File: doc/BRIEF.md
# Paged Operand Address Generator

This block works out where the operand of a 12-bit memory-reference instruction lives. It runs on a word-addressed machine with 4096 words, split into 32 pages of 128 words. The sequencer pulses `start` and presents the instruction word together with the address that instruction was fetched from. The block builds a direct address from the 7-bit in-page offset. A page-select bit chooses between page zero and the page that holds the instruction.

When the indirect bit is set, the direct address names a memory cell that holds the full 12-bit operand address. The block reads that cell through a synchronous single-port memory with one cycle of read latency. If the cell lies in the eight-word low-memory window at octal 0010 through 0017, the pointer is bumped by one, modulo 4096. The bumped value is written back and becomes the operand address. The result appears on a registered output with a single-cycle `done` pulse.

A direct reference makes no memory access. A plain indirect reference makes one read. An auto-incremented reference makes one read and one write.

Top module: `paged_ea_gen`

## Requirements
- R1: After reset, `done`, `mem_rd` and `mem_wr` are 0 and `eff_addr` is 0.
- R2: Field positions of `instr`: bit 8 is indirect, bit 7 is page select, bits 6:0 are the offset. With bit 8 = 0 and bit 7 = 0, `done` rises one cycle after `start` and `eff_addr` = {5'b0, offset}. No memory access is made.
- R3: With bit 8 = 0 and bit 7 = 1, `done` rises one cycle after `start` and `eff_addr` = {instr_addr[11:7], offset}. The page comes from the instruction's own address.
- R4: With bit 8 = 1, exactly one read is issued, at the direct address of R2/R3. It is issued for one cycle, starting one cycle after `start`.
- R5: An indirect reference whose direct address lies outside octal 0010..0017 makes no write. `done` rises three cycles after `start` and `eff_addr` equals the word read.
- R6: An indirect reference whose direct address lies inside octal 0010..0017 writes (word read + 1) mod 4096 back to that same address. `done` rises four cycles after `start` and `eff_addr` equals the written value; 7777 wraps to 0000.
- R7: `done` is a one-cycle pulse, and a read and a write are never issued in the same cycle.
- R8: A `start` that arrives while an operation is in progress is ignored. It causes no extra `done`, read or write.
- R9: Bits 11:9 of `instr` (the opcode) have no effect on the result or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin address generation for `instr` |
| instr | input | 12 | Memory-reference instruction word |
| instr_addr | input | 12 | Address the instruction was fetched from |
| mem_rdata | input | 12 | Read data, valid the cycle after a read is issued |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Memory address for read or write |
| mem_wdata | output | 12 | Write-back data (incremented pointer) |
| done | output | 1 | One-cycle pulse: `eff_addr` is final |
| eff_addr | output | 12 | Operand effective address |

## Verification
The pointer write-back of an auto-incremented reference can coincide with a fresh `start` from an impatient sequencer. The write-back cycle is the last busy cycle, so a start there must still be discarded. The bench provokes this by pulsing `start` with a different instruction exactly in the write-back cycle. It then judges the result by counting `done` pulses and memory writes over the following cycles and by reading back the pointer cell. Random references are mixed with directed ones at both edges of the window, just outside it, and at the 7777 to 0000 wrap.

// File: rtl/paged_ea_pkg.sv
package paged_ea_pkg;
  typedef enum logic [1:0] {
    EA_IDLE = 2'd0,
    EA_PTR  = 2'd1,
    EA_USE  = 2'd2,
    EA_WB   = 2'd3
  } ea_state_e;
endpackage

// File: rtl/ea_direct_addr.sv
module ea_direct_addr #(
  parameter int WORD_W = 12,
  parameter int OFF_W  = 7
) (
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] instr_addr,
  output logic [WORD_W-1:0] dir_addr,
  output logic              indirect
);
  localparam int PAGE_W = WORD_W - OFF_W;

  logic page_sel;

  always_comb begin
    page_sel = instr[OFF_W];
    indirect = instr[OFF_W+1];
    if (page_sel)
      dir_addr = {instr_addr[WORD_W-1:OFF_W], instr[OFF_W-1:0]};
    else
      dir_addr = {{PAGE_W{1'b0}}, instr[OFF_W-1:0]};
  end
endmodule

// File: rtl/ea_window_match.sv
module ea_window_match #(
  parameter int WORD_W = 12,
  parameter int BASE   = 8,
  parameter int LEN    = 8
) (
  input  logic [WORD_W-1:0] addr,
  output logic              hit
);
  localparam logic [WORD_W-1:0] LO = WORD_W'(BASE);
  localparam logic [WORD_W-1:0] HI = WORD_W'(BASE + LEN - 1);

  always_comb hit = (addr >= LO) && (addr <= HI);
endmodule

// File: rtl/ea_ptr_incr.sv
module ea_ptr_incr #(
  parameter int WORD_W = 12
) (
  input  logic [WORD_W-1:0] ptr,
  output logic [WORD_W-1:0] ptr_next
);
  always_comb ptr_next = ptr + WORD_W'(1);
endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen
  import paged_ea_pkg::*;
#(
  parameter int WORD_W   = 12,
  parameter int OFF_W    = 7,
  parameter int AIX_BASE = 8,
  parameter int AIX_LEN  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] instr_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              done,
  output logic [WORD_W-1:0] eff_addr
);
  ea_state_e         state;
  logic [WORD_W-1:0] dir_addr;
  logic              indirect;
  logic              win_hit;
  logic              aix_q;
  logic [WORD_W-1:0] ptr_inc;
  logic              busy;

  ea_direct_addr #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_direct (
    .instr      (instr),
    .instr_addr (instr_addr),
    .dir_addr   (dir_addr),
    .indirect   (indirect)
  );

  ea_window_match #(.WORD_W(WORD_W), .BASE(AIX_BASE), .LEN(AIX_LEN)) u_window (
    .addr (dir_addr),
    .hit  (win_hit)
  );

  ea_ptr_incr #(.WORD_W(WORD_W)) u_incr (
    .ptr      (mem_rdata),
    .ptr_next (ptr_inc)
  );

  assign busy = (state != EA_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= EA_IDLE;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      eff_addr  <= '0;
      aix_q     <= 1'b0;
    end else begin
      done   <= 1'b0;
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      unique case (state)
        EA_IDLE: begin
          if (start) begin
            if (indirect) begin
              mem_rd   <= 1'b1;
              mem_addr <= dir_addr;
              aix_q    <= win_hit;
              state    <= EA_PTR;
            end else begin
              eff_addr <= dir_addr;
              done     <= 1'b1;
            end
          end
        end
        EA_PTR: state <= EA_USE;
        EA_USE: begin
          if (aix_q) begin
            mem_wr    <= 1'b1;
            mem_wdata <= ptr_inc;
            eff_addr  <= ptr_inc;
            state     <= EA_WB;
          end else begin
            eff_addr <= mem_rdata;
            done     <= 1'b1;
            state    <= EA_IDLE;
          end
        end
        EA_WB: begin
          done  <= 1'b1;
          state <= EA_IDLE;
        end
        default: state <= EA_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/paged_ea_gen_chk.sv
module paged_ea_gen_chk #(
  parameter int WORD_W   = 12,
  parameter int OFF_W    = 7,
  parameter int AIX_BASE = 8,
  parameter int AIX_LEN  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic [WORD_W-1:0] instr,
  input logic [WORD_W-1:0] instr_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [WORD_W-1:0] mem_addr,
  input logic              done,
  input logic [WORD_W-1:0] eff_addr
);
  localparam int PAGE_W = WORD_W - OFF_W;
  localparam logic [WORD_W-1:0] LO = WORD_W'(AIX_BASE);
  localparam logic [WORD_W-1:0] HI = WORD_W'(AIX_BASE + AIX_LEN - 1);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!done && !mem_rd && !mem_wr));

  // R2
  page_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !instr[OFF_W+1] && !instr[OFF_W]) |=>
      (done && eff_addr == {{PAGE_W{1'b0}}, $past(instr[OFF_W-1:0])}));

  // R3
  cur_page_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !instr[OFF_W+1] && instr[OFF_W]) |=>
      (done && eff_addr == {$past(instr_addr[WORD_W-1:OFF_W]), $past(instr[OFF_W-1:0])}));

  // R4
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R6
  aix_window_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_addr >= LO && mem_addr <= HI));

  // R6
  wb_then_done_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> done);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  no_rd_wr_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> !mem_rd);
endmodule

bind paged_ea_gen paged_ea_gen_chk #(
  .WORD_W(WORD_W), .OFF_W(OFF_W), .AIX_BASE(AIX_BASE), .AIX_LEN(AIX_LEN)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .instr      (instr),
  .instr_addr (instr_addr),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_addr   (mem_addr),
  .done       (done),
  .eff_addr   (eff_addr)
);

// File: tb/test_paged_ea_gen.sv
`timescale 1ns/1ps
module test_paged_ea_gen;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] instr = '0;
  logic [W-1:0] instr_addr = '0;
  logic [W-1:0] mem_rdata;
  logic         mem_rd, mem_wr, done;
  logic [W-1:0] mem_addr, mem_wdata, eff_addr;

  logic [W-1:0] mem [4096];
  int wr_count = 0;
  int rd_count = 0;
  int done_count = 0;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  paged_ea_gen i_paged_ea_gen (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .instr_addr(instr_addr),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .done(done), .eff_addr(eff_addr)
  );

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr];
      rd_count  <= rd_count + 1;
    end
    if (mem_wr) begin
      mem[mem_addr] <= mem_wdata;
      wr_count      <= wr_count + 1;
    end
    if (done && !rst) done_count <= done_count + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0o expected %0o", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] dir_of(input logic [W-1:0] ins, input logic [W-1:0] pc);
    return ins[7] ? {pc[11:7], ins[6:0]} : {5'b0, ins[6:0]};
  endfunction

  function automatic bit in_win(input logic [W-1:0] a);
    return (a >= 12'o10) && (a <= 12'o17);
  endfunction

  // Run one reference; ptr is stored at the direct address for indirect ones.
  task automatic run_ref(input logic [W-1:0] ins, input logic [W-1:0] pc,
                         input logic [W-1:0] ptr, input string req);
    logic [W-1:0] da, exp_ea;
    int exp_lat, exp_wr, exp_rd, lat, wr0, rd0;
    da = dir_of(ins, pc);
    if (ins[8]) mem[da] = ptr;
    if (!ins[8])          begin exp_ea = da;             exp_lat = 1; exp_wr = 0; exp_rd = 0; end
    else if (!in_win(da)) begin exp_ea = ptr;            exp_lat = 3; exp_wr = 0; exp_rd = 1; end
    else                  begin exp_ea = ptr + 12'd1;    exp_lat = 4; exp_wr = 1; exp_rd = 1; end
    wr0 = wr_count; rd0 = rd_count;
    instr = ins; instr_addr = pc; start = 1'b1;
    @(negedge clk);
    start = 1'b0; instr = $urandom; instr_addr = $urandom;
    lat = 1;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    chk(done && eff_addr == exp_ea, req, eff_addr, exp_ea);
    chk(lat == exp_lat, {req, " latency"}, lat, exp_lat);
    chk(wr_count - wr0 == exp_wr, {req, " writes"}, wr_count - wr0, exp_wr);
    chk(rd_count - rd0 == exp_rd, {req, " reads"}, rd_count - rd0, exp_rd);
    if (exp_wr == 1) chk(mem[da] == exp_ea, {req, " writeback"}, mem[da], exp_ea);
    else if (ins[8]) chk(mem[da] == ptr, {req, " cell untouched"}, mem[da], ptr);
    @(negedge clk);
    chk(!done, "R7 done pulse", done, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    for (int i = 0; i < 4096; i++) mem[i] = 12'(i * 5 + 3);
    repeat (3) @(negedge clk);
    chk(!done && !mem_rd && !mem_wr && eff_addr == 0, "R1 reset", done, 0);
    rst = 1'b0;
    @(negedge clk);

    // directed
    run_ref(12'o1055, 12'o2345, 0, "R2 page zero");
    run_ref(12'o1255, 12'o2345, 0, "R3 current page");
    run_ref(12'o1377, 12'o0177, 0, "R3 page end");
    run_ref(12'o1200, 12'o0200, 0, "R3 page one");
    run_ref(12'o1420, 12'o0200, 12'o4321, "R4 R5 indirect outside");
    run_ref(12'o1407, 12'o0200, 12'o1111, "R5 below window");
    run_ref(12'o1410, 12'o0200, 12'o3000, "R6 window low");
    run_ref(12'o1417, 12'o0200, 12'o0777, "R6 window high");
    run_ref(12'o1413, 12'o0200, 12'o7777, "R6 wrap");
    run_ref(12'o1610, 12'o0000, 12'o0042, "R6 current page zero");
    run_ref(12'o7055, 12'o2345, 0, "R9 opcode ignored direct");
    run_ref(12'o5413, 12'o0200, 12'o0100, "R9 opcode ignored aix");

    // R8: start pulsed in the write-back cycle of an auto-increment reference
    begin
      int d0, w0, r0;
      mem[12'o14] = 12'o0500;
      d0 = done_count; w0 = wr_count; r0 = rd_count;
      instr = 12'o0414; instr_addr = 12'o0300; start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      instr = 12'o0415; start = 1'b1;      // write-back cycle
      @(negedge clk); start = 1'b0;
      chk(done && eff_addr == 12'o0501, "R8 busy op result", eff_addr, 12'o0501);
      repeat (6) @(negedge clk);
      chk(done_count - d0 == 1, "R8 extra done", done_count - d0, 1);
      chk(wr_count - w0 == 1 && rd_count - r0 == 1, "R8 extra access",
          wr_count - w0 + rd_count - r0, 2);
      chk(mem[12'o15] == 12'o0015 * 5 + 3, "R8 cell untouched", mem[12'o15], 12'o0015 * 5 + 3);
    end

    // random
    for (int n = 0; n < 300; n++) begin
      logic [W-1:0] ins;
      ins = 12'($urandom);
      if (n % 4 == 0) ins = {ins[11:9], 2'b10, 4'b0001, ins[2:0]};
      run_ref(ins, 12'($urandom), 12'($urandom), "R2-6 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule